// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Front End

This block is the device-side front end of a 16-bit parallel NOR-style flash. It watches the active-low chip-enable, output-enable, write-enable, address-valid and reset strobes, plus an optional bus clock. From these it classifies every moment on the bus as a read, a write, an output-off state, standby or reset. It keeps an address latch whose behaviour depends on a mode input. In asynchronous mode the latch is transparent while address-valid is low and holds once that strobe rises. In synchronous mode the address is captured once, at the earlier of the address-valid rise or a bus-clock rise that comes while address-valid is low.

A small word array stands in for the flash storage. A write stores the bus data on whichever strobe rises first, write-enable or chip-enable. A read drives the stored word and a deasserted wait flag onto the shared lines. In every other state the data bus and the wait line float. All pins are sampled on an internal clock, so edges are seen as changes between consecutive samples. The upper bits of the effective address are presented as a block index.

Top module: `pflash_bus_front`

## Requirements
- R1: When chip-enable and output-enable are low and write-enable and reset are high at a sampling edge, the next cycle drives the word stored at the effective address onto the data bus and drives the wait line low (deasserted).
- R2: In a write state (chip-enable and write-enable low, output-enable and reset high), the data on the bus is stored at the effective address on the first sampled rise of either write-enable or chip-enable. A later rise of the other strobe stores nothing.
- R3: The data bus and the wait line are released (high impedance) in the same cycle that any of these holds: output-enable high, chip-enable high, reset low, or write-enable low.
- R4: While write-enable is low the block never drives the data bus or the wait line, so a host write never meets a driven bus.
- R5: In asynchronous mode (mode input low) with address-valid low, the effective address follows the address input with no capture edge needed.
- R6: In asynchronous mode, once address-valid is high the effective address keeps the last value sampled while it was low, whatever the address input does.
- R7: In synchronous mode (mode input high) the address is captured at the first of an address-valid rise or a bus-clock rise with address-valid low. Further bus-clock or address-valid rises are ignored until address-valid falls again.
- R8: A synchronous capture takes place only while chip-enable is low and write-enable and reset are high. A capture event with chip-enable high leaves the latch unchanged.
- R9: The block-index output equals the top BLK_W bits of the effective address.
- R10: Reset low clears the address latch to zero and the read data register, but leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Device reset, active low |
| syncMode | input | 1 | Address mode: 0 asynchronous, 1 synchronous |
| busClk | input | 1 | Bus clock used by synchronous capture |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| advN | input | 1 | Address valid, active low |
| addr | input | ADDR_W | Word address |
| dq | inout | DATA_W | Shared data bus |
| waitPin | output | 1 | Wait flag, driven low during reads, otherwise floating |
| blockIdx | output | BLK_W | Block selected by the effective address |

## Verification
The hardest cases to reach are the edge races. One is a chip-enable rise that ends a write ahead of write-enable, with the host then changing the bus data before write-enable rises. The other is a synchronous capture that has already happened when a second bus-clock edge or the address-valid rise arrives with a new address. Directed sequences build each race one sampling cycle at a time, and the read-back value shows which address or data won. Randomized writes and reads in both modes then run against a bench model of the array, and the bus is checked to float after every read.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_OUTOFF  = 3'd2,
    OP_READ    = 3'd3,
    OP_WRITE   = 3'd4
  } busOp_e;

  typedef struct packed {
    logic clearAll;   // reset pin low: clear latch and read register
    logic flowThru;   // async mode with address-valid low
    logic capture;    // load address latch this cycle
    logic commit;     // store bus data to the array
    logic rdActive;   // read state present on the pins now
  } ctlStrobes_t;

endpackage

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncMode,
  input  logic        busClk,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        advN,
  output ctlStrobes_t strobes,
  output busOp_e      busOp
);

  logic advQ;
  logic bclkQ;
  logic wasWriteQ;
  logic capturedQ;

  logic advRise;
  logic advFall;
  logic bclkRise;
  logic syncOk;
  logic syncArmed;
  logic syncCap;

  // bus state decode, priority reset > standby > read/write > off
  always_comb begin
    if (!rstN)                     busOp = OP_RESET;
    else if (ceN)                  busOp = OP_STANDBY;
    else if (!oeN && weN)          busOp = OP_READ;
    else if (oeN && !weN)          busOp = OP_WRITE;
    else                           busOp = OP_OUTOFF;
  end

  assign advRise   = !advQ && advN;
  assign advFall   = advQ && !advN;
  assign bclkRise  = busClk && !bclkQ;
  assign syncOk    = rstN && !ceN && weN;
  assign syncArmed = !capturedQ || advFall;
  assign syncCap   = syncMode && syncOk && syncArmed &&
                     (advRise || (bclkRise && !advN));

  always_comb begin
    strobes          = '0;
    strobes.clearAll = !rstN;
    strobes.flowThru = rstN && !syncMode && !advN;
    strobes.capture  = rstN && ((!syncMode && !advN) || syncCap);
    strobes.commit   = rstN && wasWriteQ && (weN || ceN);
    strobes.rdActive = (busOp == OP_READ);
  end

  always_ff @(posedge clk) begin
    advQ  <= advN;
    bclkQ <= busClk;
    if (!rstN) begin
      wasWriteQ <= 1'b0;
      capturedQ <= 1'b0;
    end else begin
      wasWriteQ <= (busOp == OP_WRITE);
      if (syncCap)      capturedQ <= 1'b1;
      else if (advFall) capturedQ <= 1'b0;
    end
  end

endmodule

// File: rtl/pflash_datapath.sv
module pflash_datapath
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 2
)(
  input  logic              clk,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [BLK_W-1:0]  blockIdx
);

  localparam int WORDS = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] doutReg;
  logic              driveQ;
  logic [DATA_W-1:0] mem [WORDS];

  assign effAddr  = strobes.flowThru ? addr : addrReg;
  assign blockIdx = effAddr[ADDR_W-1 -: BLK_W];

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      addrReg <= '0;
      doutReg <= '0;
      driveQ  <= 1'b0;
    end else begin
      if (strobes.capture)  addrReg <= addr;
      if (strobes.rdActive) doutReg <= mem[effAddr];
      driveQ <= strobes.rdActive;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) mem[effAddr] <= dqIn;
  end

  // turn-on waits one cycle, turn-off follows the pins at once
  assign dqOe  = driveQ && strobes.rdActive;
  assign dqOut = doutReg;

endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              busClk,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq,
  output wire               waitPin,
  output logic [BLK_W-1:0]  blockIdx
);

  ctlStrobes_t       strobes;
  busOp_e            busOp;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  pflash_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncMode (syncMode),
    .busClk   (busClk),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .advN     (advN),
    .strobes  (strobes),
    .busOp    (busOp)
  );

  pflash_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BLK_W  (BLK_W)
  ) i_dp (
    .clk      (clk),
    .strobes  (strobes),
    .addr     (addr),
    .dqIn     (dq),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .blockIdx (blockIdx)
  );

  assign dq      = dqOe ? dqOut : {DATA_W{1'bz}};
  assign waitPin = dqOe ? 1'b0 : 1'bz;

endmodule

// File: rtl/pflash_checker.sv
module pflash_checker #(
  parameter int BLK_W = 2
)(
  input logic             clk,
  input logic             rstN,
  input logic             syncMode,
  input logic             ceN,
  input logic             oeN,
  input logic             weN,
  input logic             advN,
  input logic [BLK_W-1:0] blockIdx,
  input logic             dqOe
);

  // R3: idle or output-off pins never see a driven bus
  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> !dqOe);

  // R4: no drive while the host may be writing
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> weN);

  // R1: a driven bus was preceded by a read state one sample earlier
  p_drive_after_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(rstN)) |-> $past(!ceN && !oeN && weN));

  // R6: async latch holds while address-valid stays high
  p_async_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && advN && $past(!syncMode && advN && rstN)) |-> $stable(blockIdx));

  // R7: sync latch holds when no address-valid edge was near
  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && advN && $past(syncMode && advN && rstN) &&
     $past(advN && rstN, 2)) |-> $stable(blockIdx));

endmodule

bind pflash_bus_front pflash_checker #(.BLK_W(BLK_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .syncMode (syncMode),
  .ceN      (ceN),
  .oeN      (oeN),
  .weN      (weN),
  .advN     (advN),
  .blockIdx (blockIdx),
  .dqOe     (dqOe)
);

// File: tb/test_pflash_bus_front.sv
`timescale 1ns/1ps
module test_pflash_bus_front;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam logic [DW-1:0] FLOAT = {DW{1'b1}};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          syncMode = 1'b1;
  logic          busClk = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1, advN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] hostDq = '0;
  logic          hostDrive = 1'b0;
  wire  [DW-1:0] dqBus;
  wire           waitBus;
  logic [BW-1:0] blockIdx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] model [1<<AW];
  logic [AW-1:0] addrList [1<<AW];
  bit            written [1<<AW];
  int            nList = 0;

  always #4 clk = ~clk;

  // tri-state resolver: host driver plus pull-ups so a floating line reads high
  assign dqBus = hostDrive ? hostDq : {DW{1'bz}};
  for (genvar g = 0; g < DW; g++) begin : g_pull
    pullup pu (dqBus[g]);
  end
  pullup puw (waitBus);

  pflash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW)) i_pflash_bus_front (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .busClk(busClk),
    .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN), .addr(addr),
    .dq(dqBus), .waitPin(waitBus), .blockIdx(blockIdx)
  );

  function automatic logic [BW-1:0] expBlk(input logic [AW-1:0] a);
    return a[AW-1 -: BW];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; advN = 1'b1; busClk = 1'b0;
    hostDrive = 1'b0;
  endtask

  task automatic latchAddr(input logic [AW-1:0] a);
    ceN = 1'b0; weN = 1'b1; oeN = 1'b1; addr = a; advN = 1'b0;
    step();
    if (syncMode) begin
      busClk = 1'b1; step(); busClk = 1'b0;
    end
    advN = 1'b1;
    step();
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    latchAddr(a);
    weN = 1'b0; hostDq = d; hostDrive = 1'b1;
    step();
    check(waitBus === 1'b1, "R4 wait floats during write", waitBus, 1);
    weN = 1'b1;
    step();
    ceN = 1'b1; hostDrive = 1'b0;
    step();
    model[a] = d;
    if (!written[a]) begin written[a] = 1'b1; addrList[nList] = a; nList++; end
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    latchAddr(a);
    oeN = 1'b0;
    step();
    check(dqBus === model[a], "R1 read data", dqBus, model[a]);
    check(waitBus === 1'b0, "R1 wait driven low", waitBus, 0);
    check(blockIdx === expBlk(a), "R9 block index", blockIdx, expBlk(a));
    oeN = 1'b1;
    #1;
    check(dqBus === FLOAT, "R3 float after output-enable high", dqBus, FLOAT);
    check(waitBus === 1'b1, "R3 wait floats", waitBus, 1);
    ceN = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a1, a2, a3;
    logic [DW-1:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < (1<<AW); i++) written[i] = 1'b0;
    idle();
    step(3);
    // R10: reset clears latch, bus floats during reset
    check(blockIdx === '0, "R10 latch cleared by reset", blockIdx, 0);
    check(dqBus === FLOAT, "R3 float in reset", dqBus, FLOAT);
    rstN = 1'b1;
    step(2);
    check(blockIdx === '0, "R10 latch zero after reset", blockIdx, 0);

    a1 = 8'h1C; a2 = 8'hA7; a3 = 8'h63;
    syncMode = 1'b0;
    doWrite(a1, 16'h1111);
    doWrite(a2, 16'h2222);

    // R5 flow-through, then R6 hold in async mode
    ceN = 1'b0; oeN = 1'b0; advN = 1'b0; addr = a1;
    step();
    check(dqBus === model[a1], "R5 flow-through first", dqBus, model[a1]);
    addr = a2;
    step();
    check(dqBus === model[a2], "R5 flow-through follows", dqBus, model[a2]);
    check(blockIdx === expBlk(a2), "R9 block index flow", blockIdx, expBlk(a2));
    advN = 1'b1;
    step();
    addr = a1;
    step(2);
    check(dqBus === model[a2], "R6 async hold", dqBus, model[a2]);
    check(blockIdx === expBlk(a2), "R6 async hold index", blockIdx, expBlk(a2));
    // R3/R4: output-enable and write-enable both low -> float
    weN = 1'b0;
    #1;
    check(dqBus === FLOAT, "R4 float with write-enable low", dqBus, FLOAT);
    idle();
    step();
    // R3: standby with output-enable low
    oeN = 1'b0;
    step();
    check(dqBus === FLOAT, "R3 float in standby", dqBus, FLOAT);
    idle();
    step();

    // R2: chip-enable rises first, later write-enable rise stores nothing
    latchAddr(a3);
    weN = 1'b0; hostDq = 16'h3333; hostDrive = 1'b1;
    step();
    ceN = 1'b1;
    step();
    hostDq = 16'h4444;
    step();
    weN = 1'b1;
    step();
    hostDrive = 1'b0;
    step();
    model[a3] = 16'h3333; written[a3] = 1'b1; addrList[nList] = a3; nList++;
    doRead(a3);

    // R7: sync capture at bus clock, later edges ignored
    syncMode = 1'b1;
    ceN = 1'b0; advN = 1'b0; addr = a1;
    step();
    busClk = 1'b1; step(); busClk = 1'b0;
    addr = a2;
    step();
    busClk = 1'b1; step(); busClk = 1'b0;
    advN = 1'b1;
    step();
    oeN = 1'b0;
    step();
    check(dqBus === model[a1], "R7 first bus-clock edge wins", dqBus, model[a1]);
    idle();
    step();
    // R7: capture on address-valid rise with no clock edge
    ceN = 1'b0; advN = 1'b0; addr = a2;
    step();
    advN = 1'b1;
    step();
    addr = a3;
    oeN = 1'b0;
    step();
    check(dqBus === model[a2], "R7 address-valid rise capture", dqBus, model[a2]);
    idle();
    step();
    // R8: capture event with chip-enable high is ignored
    latchAddr(a1);
    idle();
    addr = a3; advN = 1'b0;
    step();
    busClk = 1'b1; step(); busClk = 1'b0;
    advN = 1'b1;
    step();
    ceN = 1'b0; oeN = 1'b0;
    step();
    check(dqBus === model[a1], "R8 no capture with chip-enable high", dqBus, model[a1]);
    // R3: reset during a read floats at once; R10 clears latch
    rstN = 1'b0;
    #1;
    check(dqBus === FLOAT, "R3 float on reset", dqBus, FLOAT);
    check(waitBus === 1'b1, "R3 wait floats on reset", waitBus, 1);
    idle();
    step(2);
    rstN = 1'b1;
    step();
    check(blockIdx === '0, "R10 latch cleared", blockIdx, 0);
    doRead(a2);  // R10 array retained

    // randomized mix in both modes
    for (int i = 0; i < 300; i++) begin
      syncMode = 1'($urandom_range(0, 1));
      if (nList == 0 || $urandom_range(0, 1) == 0) begin
        a1 = AW'($urandom);
        d  = DW'($urandom) & 16'h7FFF;
        doWrite(a1, d);
      end else begin
        a1 = addrList[$urandom_range(0, nList - 1)];
        doRead(a1);
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule